// File: doc/BRIEF.md
# Two-Wire Serial Programming Host Sequencer

This block is the host end of a two-wire serial programming link. It produces the programming clock and a bidirectional data line, and it asks an external high-voltage stage to put the target into programming mode. After that it writes one 14-bit word per request. For each request it sends a load-data command and a framed data word, a begin-programming command, a read-data command, and then an increment-address command. It captures the word that the target returns and compares it with the word it sent. Every phase is separated by an idle gap of at least one microsecond.

A request is one cycle of `req_valid` together with a data word. When `req_id` is set, the word is built as an identification entry, with the upper bits fixed and the 4 ID bits in the low nibble. The clock timing comes from the `CLK_HZ` and `PCLK_HZ` parameters. The half period is HALF = ceil(CLK_HZ / (2*PCLK_HZ)) system cycles and the gap is GAP = ceil(CLK_HZ / 1e6) system cycles. At the end of each request `done` pulses. `mismatch` records, until reset, any word that read back differently.

Top module: `spp_host`

## Requirements
- R1: On the first edge after reset, `entry_req` goes high and then stays high. For the first GAP cycles after reset, `prog_clk` is low and the data line is driven to 0. After that the line is released.
- R2: Each programming clock pulse is high for exactly HALF cycles. Within a frame, the clock is low for exactly HALF cycles between pulses.
- R3: A command is 6 pulses with the least significant bit first, and the data line is driven during them. Command codes: load data 6'h02, begin programming 6'h08, read data 6'h04, increment address 6'h06. Each bit holds its value for the whole high phase of its pulse, through the falling edge.
- R4: Between the last pulse of any frame and the first pulse of the next frame, including across requests, the clock stays low for at least GAP cycles.
- R5: A write frame is 16 driven pulses. Pulse 0 (start) and pulse 15 (stop) carry 0. Pulses 1 to 14 carry the word, least significant bit first.
- R6: A read frame is 16 pulses with the data line released throughout. `prog_dat_in` is sampled at the falling edge of pulses 1 to 14, least significant bit first.
- R7: Each request issues, in this order: load data plus a write frame, begin programming, read data plus a read frame, and increment address. That is 56 clock pulses in total.
- R8: With `req_id` set, the word sent is 14'h3F80 OR `req_data[3:0]`. The other bits of `req_data` are ignored.
- R9: `mismatch` is set when the 14 bits read back differ from the word sent. It stays set until reset.
- R10: `done` is high for exactly one cycle, after the final gap. While idle, `prog_clk` is low and the data line is released.
- R11: A request that arrives while an operation is in progress is ignored. It changes neither the current word nor the pulse count, and no operation follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe, accepted only when idle |
| req_id | input | 1 | Selects an ID-word write |
| req_data | input | W | Word to write (low nibble for an ID write) |
| done | output | 1 | One-cycle pulse at the end of a request |
| mismatch | output | 1 | Sticky read-back mismatch flag |
| entry_req | output | 1 | Request to the external programming-mode entry stage |
| prog_clk | output | 1 | Programming clock |
| prog_dat_out | output | 1 | Data line output value |
| prog_dat_oe | output | 1 | Data line output enable |
| prog_dat_in | input | 1 | Data line input value |

## Verification
The bench models the target at the pins. It decodes every command and frame from clock edges and measures each high and low interval in system cycles. A wrong step counter or frame decode shows up at the next command boundary, as an out-of-order code or a wrong pulse count. A wrong timer shows up within one pulse, as a high or low width that is off. A bad capture or compare path shows up in `mismatch` by the `done` pulse of the same request, or fails to show up when the bench corrupts the read-back word.

// File: rtl/spp_pkg.sv
package spp_pkg;
    localparam logic [5:0] CMD_LOAD  = 6'h02;
    localparam logic [5:0] CMD_BEGIN = 6'h08;
    localparam logic [5:0] CMD_READ  = 6'h04;
    localparam logic [5:0] CMD_INC   = 6'h06;
    localparam logic [13:0] ID_PATTERN = 14'h3F80;

    typedef enum logic [1:0] {
        ST_ENTRY,
        ST_IDLE,
        ST_SHIFT,
        ST_GAP
    } seq_state_e;

    function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
        return (a + b - 1) / b;
    endfunction
endpackage

// File: rtl/spp_step_decode.sv
module spp_step_decode #(
    parameter int unsigned W  = 14,
    parameter int unsigned FW = W + 2,
    parameter int unsigned BW = 5
) (
    input  logic [2:0]    step,
    input  logic [W-1:0]  word,
    output logic [FW-1:0] frame,
    output logic [BW-1:0] last_bit,
    output logic          is_rx,
    output logic          is_final
);
    import spp_pkg::*;

    localparam logic [BW-1:0] CMD_LAST  = BW'(5);
    localparam logic [BW-1:0] WORD_LAST = BW'(FW - 1);

    always_comb begin
        frame    = '0;
        last_bit = CMD_LAST;
        is_rx    = 1'b0;
        is_final = 1'b0;
        case (step)
            3'd0: frame = FW'(CMD_LOAD);
            3'd1: begin
                frame    = {1'b0, word, 1'b0};
                last_bit = WORD_LAST;
            end
            3'd2: frame = FW'(CMD_BEGIN);
            3'd3: frame = FW'(CMD_READ);
            3'd4: begin
                last_bit = WORD_LAST;
                is_rx    = 1'b1;
            end
            default: begin
                frame    = FW'(CMD_INC);
                is_final = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/spp_rx_capture.sv
module spp_rx_capture #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         sample,
    input  logic         din,
    input  logic [W-1:0] expect_word,
    output logic         match
);
    logic [W-1:0] buf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (clear) begin
            buf_q <= '0;
        end else if (sample) begin
            buf_q <= {din, buf_q[W-1:1]};
        end
    end

    assign match = (buf_q == expect_word);
endmodule

// File: rtl/spp_host.sv
module spp_host #(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned PCLK_HZ = 1_000_000,
    parameter int unsigned W       = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic         req_id,
    input  logic [W-1:0] req_data,
    output logic         done,
    output logic         mismatch,
    output logic         entry_req,
    output logic         prog_clk,
    output logic         prog_dat_out,
    output logic         prog_dat_oe,
    input  logic         prog_dat_in
);
    import spp_pkg::*;

    localparam int unsigned HALF = ceil_div(CLK_HZ, 2 * PCLK_HZ);
    localparam int unsigned GAP  = ceil_div(CLK_HZ, 1_000_000);
    localparam int unsigned TMAX = (HALF > GAP) ? HALF : GAP;
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam int unsigned FW   = W + 2;
    localparam int unsigned BW   = $clog2(FW + 1);

    typedef struct packed {
        seq_state_e     st;
        logic [2:0]     step;
        logic [BW-1:0]  bitn;
        logic           hi;
        logic [TW-1:0]  tmr;
        logic [FW-1:0]  sh;
        logic [W-1:0]   word;
        logic           mism;
        logic           done;
        logic           entry;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [2:0]    nxt_step;
    logic [FW-1:0] nxt_frame, cur_frame;
    logic [BW-1:0] nxt_last, cur_last;
    logic          nxt_rx, nxt_fin, cur_rx, cur_fin;
    logic          cap_clear, cap_sample, cap_match;

    assign nxt_step = (q.st == ST_IDLE) ? 3'd0 : q.step + 3'd1;

    spp_step_decode #(.W(W), .FW(FW), .BW(BW)) u_dec_next (
        .step(nxt_step), .word(q.word), .frame(nxt_frame),
        .last_bit(nxt_last), .is_rx(nxt_rx), .is_final(nxt_fin)
    );

    spp_step_decode #(.W(W), .FW(FW), .BW(BW)) u_dec_cur (
        .step(q.step), .word(q.word), .frame(cur_frame),
        .last_bit(cur_last), .is_rx(cur_rx), .is_final(cur_fin)
    );

    spp_rx_capture #(.W(W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(cap_clear), .sample(cap_sample),
        .din(prog_dat_in), .expect_word(q.word), .match(cap_match)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.entry    = 1'b1;
        cap_clear  = 1'b0;
        cap_sample = 1'b0;
        case (q.st)
            ST_ENTRY: begin
                if (q.tmr == '0) d.st = ST_IDLE;
                else d.tmr = q.tmr - TW'(1);
            end
            ST_IDLE: begin
                if (req_valid) begin
                    d.word = req_id ? (W'(ID_PATTERN) | W'(req_data[3:0])) : req_data;
                    d.st   = ST_SHIFT;
                    d.step = nxt_step;
                    d.bitn = '0;
                    d.hi   = 1'b1;
                    d.tmr  = TW'(HALF - 1);
                    d.sh   = nxt_frame;
                end
            end
            ST_SHIFT: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - TW'(1);
                end else if (q.hi) begin
                    d.hi       = 1'b0;
                    d.tmr      = TW'(HALF - 1);
                    cap_sample = cur_rx && (q.bitn >= BW'(1)) && (q.bitn <= BW'(W));
                end else if (q.bitn == cur_last) begin
                    d.st  = ST_GAP;
                    d.tmr = TW'(GAP - 1);
                    if (cur_rx && !cap_match) d.mism = 1'b1;
                end else begin
                    d.bitn = q.bitn + BW'(1);
                    d.hi   = 1'b1;
                    d.tmr  = TW'(HALF - 1);
                    d.sh   = q.sh >> 1;
                end
            end
            default: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - TW'(1);
                end else if (cur_fin) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.st      = ST_SHIFT;
                    d.step    = nxt_step;
                    d.bitn    = '0;
                    d.hi      = 1'b1;
                    d.tmr     = TW'(HALF - 1);
                    d.sh      = nxt_frame;
                    cap_clear = nxt_rx;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_ENTRY;
            q.tmr   <= TW'(GAP - 1);
        end else begin
            q <= d;
        end
    end

    logic unused_ok;
    assign unused_ok = ^{cur_frame, nxt_last, nxt_fin};

    assign prog_clk     = (q.st == ST_SHIFT) && q.hi;
    assign prog_dat_oe  = (q.st == ST_ENTRY) || ((q.st == ST_SHIFT) && !cur_rx);
    assign prog_dat_out = prog_dat_oe && q.sh[0];
    assign done         = q.done;
    assign mismatch     = q.mism;
    assign entry_req    = q.entry;
endmodule

// File: rtl/spp_host_chk.sv
module spp_host_chk #(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned PCLK_HZ = 1_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic prog_clk,
    input logic prog_dat_out,
    input logic prog_dat_oe,
    input logic entry_req,
    input logic done,
    input logic mismatch
);
    import spp_pkg::*;

    localparam int unsigned HALF = ceil_div(CLK_HZ, 2 * PCLK_HZ);

    logic [15:0] lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lo_cnt <= '0;
        else if (prog_clk) lo_cnt <= '0;
        else if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 16'd1;
    end

    // R1
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_req |=> entry_req);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!prog_clk && !prog_dat_oe));

    // R9
    sticky_mism_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> mismatch);

    // R3
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_clk && $past(prog_clk)) |-> $stable(prog_dat_out));

    // R2
    low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_clk) |-> (lo_cnt >= 16'(HALF)));
endmodule

bind spp_host spp_host_chk #(.CLK_HZ(CLK_HZ), .PCLK_HZ(PCLK_HZ)) u_spp_host_chk (
    .clk(clk), .rst_n(rst_n), .prog_clk(prog_clk), .prog_dat_out(prog_dat_out),
    .prog_dat_oe(prog_dat_oe), .entry_req(entry_req), .done(done), .mismatch(mismatch)
);

// File: tb/test_spp_host.sv
module test_spp_host;
    localparam int unsigned CLK_HZ  = 10_000_000;
    localparam int unsigned PCLK_HZ = 1_000_000;
    localparam int HALF_E = (CLK_HZ + 2 * PCLK_HZ - 1) / (2 * PCLK_HZ);
    localparam int GAP_E  = (CLK_HZ + 1_000_000 - 1) / 1_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_id = 1'b0;
    logic [13:0] req_data = '0;
    logic        done, mismatch, entry_req, prog_clk, prog_dat_out, prog_dat_oe;
    logic        prog_dat_in = 1'b0;

    spp_host #(.CLK_HZ(CLK_HZ), .PCLK_HZ(PCLK_HZ), .W(14)) i_spp_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .req_data(req_data), .done(done), .mismatch(mismatch), .entry_req(entry_req),
        .prog_clk(prog_clk), .prog_dat_out(prog_dat_out), .prog_dat_oe(prog_dat_oe),
        .prog_dat_in(prog_dat_in)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int m_chk = 0, m_fail = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Target model at the pins
    logic [13:0] tmem [0:63];
    logic [5:0]  taddr;
    logic [13:0] tload, rdval, corrupt;
    logic [15:0] acc;
    int tmode, tbit, cidx, rises, hi_run, lo_run;
    logic prev_clk, rise_dat;
    logic [5:0] exp_seq [0:3];

    initial begin
        exp_seq[0] = 6'h02; exp_seq[1] = 6'h08; exp_seq[2] = 6'h04; exp_seq[3] = 6'h06;
        corrupt = '0;
    end

    task automatic mchk(input bit ok, input string req, input int act, input int exp);
        m_chk++;
        if (!ok) begin
            m_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            taddr = '0; tload = '0; rdval = '0; acc = '0;
            tmode = 0; tbit = 0; cidx = 0; rises = 0; hi_run = 0; lo_run = 0;
            prev_clk = 1'b0; rise_dat = 1'b0;
            for (int i = 0; i < 64; i++) tmem[i] = '0;
        end else begin
            if (prog_clk && !prev_clk) begin
                rises++;
                if (tbit == 0) mchk(lo_run >= GAP_E, "R4 gap", lo_run, GAP_E);
                else mchk(lo_run == HALF_E, "R2 low", lo_run, HALF_E);
                if (tmode == 2) prog_dat_in = (tbit >= 1 && tbit <= 14) ? rdval[tbit-1] : 1'b0;
                rise_dat = prog_dat_out;
                hi_run = 1;
            end else if (!prog_clk && prev_clk) begin
                mchk(hi_run == HALF_E, "R2 high", hi_run, HALF_E);
                if (tmode == 2) mchk(!prog_dat_oe, "R6 released", prog_dat_oe, 0);
                else begin
                    mchk(prog_dat_oe, "R3 driven", prog_dat_oe, 1);
                    mchk(prog_dat_out == rise_dat, "R3 stable", prog_dat_out, rise_dat);
                end
                acc[tbit] = prog_dat_out;
                tbit++;
                if (tmode == 0 && tbit == 6) begin
                    mchk(acc[5:0] == exp_seq[cidx], "R7 order", acc[5:0], exp_seq[cidx]);
                    cidx = (cidx + 1) % 4;
                    case (acc[5:0])
                        6'h02: tmode = 1;
                        6'h04: begin tmode = 2; rdval = tmem[taddr] ^ corrupt; end
                        6'h08: tmem[taddr] = tload;
                        6'h06: taddr = taddr + 6'd1;
                        default: ;
                    endcase
                    tbit = 0;
                end else if (tmode != 0 && tbit == 16) begin
                    if (tmode == 1) begin
                        mchk(acc[0] == 1'b0 && acc[15] == 1'b0, "R5 start/stop", {acc[15], acc[0]}, 0);
                        tload = acc[14:1];
                    end
                    tmode = 0;
                    tbit = 0;
                    prog_dat_in = 1'b0;
                end
                lo_run = 1;
            end else if (prog_clk) begin
                hi_run++;
            end else begin
                lo_run++;
            end
            prev_clk = prog_clk;
        end
    end

    task automatic do_op(input bit id, input logic [13:0] dat, input bit inject,
                         input logic [13:0] cmask, input bit exp_mism);
        logic [13:0] expw;
        logic [5:0]  a0;
        int r0, n, r1;
        expw = id ? (14'h3F80 | {10'b0, dat[3:0]}) : dat;
        a0 = taddr;
        r0 = rises;
        corrupt = cmask;
        @(negedge clk);
        req_valid = 1'b1; req_id = id; req_data = dat;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
            if (inject && n == 200) begin
                req_valid = 1'b1; req_id = 1'b0; req_data = ~dat;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        check(done, "R10 done seen", done, 1);
        @(negedge clk);
        check(!done, "R10 done one cycle", done, 0);
        check(!prog_clk && !prog_dat_oe, "R10 idle lines", {prog_clk, prog_dat_oe}, 0);
        check(tload == expw, id ? "R8 id word" : "R7 word", tload, expw);
        check(tmem[a0] == expw, "R7 programmed", tmem[a0], expw);
        check(taddr == a0 + 6'd1, "R7 increment", taddr, a0 + 6'd1);
        check(rises - r0 == 56, "R7 pulses", rises - r0, 56);
        check(mismatch == exp_mism, "R9 mismatch", mismatch, exp_mism);
        if (inject) begin
            r1 = rises;
            repeat (3 * GAP_E) @(negedge clk);
            check(rises == r1, "R11 ignored request", rises - r1, 0);
        end
        corrupt = '0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 180000) begin
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk + m_chk + 1, n_fail + m_fail + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!entry_req && !prog_clk && !done && !mismatch, "R1 reset state",
              {entry_req, prog_clk, done, mismatch}, 0);
        rst_n = 1'b1;
        for (int k = 1; k < GAP_E; k++) begin
            @(negedge clk);
            check(entry_req && !prog_clk && prog_dat_oe && !prog_dat_out, "R1 entry hold",
                  {entry_req, prog_clk, prog_dat_oe, prog_dat_out}, 4'b1010);
        end
        repeat (3) @(negedge clk);
        check(entry_req && !prog_dat_oe && !prog_clk, "R1 release",
              {entry_req, prog_dat_oe, prog_clk}, 3'b100);

        for (int b = 0; b < 16; b++) do_op(1'b1, {6'h15, 4'(b)} << 0, 1'b0, '0, 1'b0);
        do_op(1'b0, 14'h0000, 1'b0, '0, 1'b0);
        do_op(1'b0, 14'h3FFF, 1'b0, '0, 1'b0);
        do_op(1'b0, 14'h2AAA, 1'b0, '0, 1'b0);
        do_op(1'b0, 14'h1555, 1'b0, '0, 1'b0);
        for (int b = 0; b < 14; b++) do_op(1'b0, 14'(1) << b, 1'b0, '0, 1'b0);
        do_op(1'b0, 14'h1234, 1'b1, '0, 1'b0);
        do_op(1'b0, 14'h0F0F, 1'b0, 14'h0020, 1'b1);
        do_op(1'b0, 14'h30C3, 1'b0, '0, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_chk + m_chk, n_fail + m_fail);
        $finish;
    end
endmodule